// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block decides when and how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) leaves its normal flow for a trap handler. Every stage except writeback sends the block its own fault strobes and the PC of the instruction it holds. When an instruction faults, the block attaches a trap tag to it. The tag moves with the instruction, one stage per cycle. While the tag is in flight, the stages behind it are held and a bubble is placed directly behind the tagged instruction. When the tag reaches writeback, the block flushes every stage, stores the faulting PC and a 4-bit cause, and steers fetch to a fixed handler address.

External interrupts are handled differently. The block holds fetch and lets every instruction already past fetch retire. It then redirects and saves the PC of the held fetch instruction, so execution restarts there. An exception always takes priority over a pending interrupt. When faults occur in several stages, the instruction furthest down the pipe wins.

Output bit s of the hold and bubble vectors refers to stage s: 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback. Hold means the stage keeps its contents for the next cycle. Bubble means the stage is loaded with an empty slot for the next cycle.

Top module: `trap_ctrl`

## Requirements
- R1: `if_flt_i` bit 0 (page fault), bit 1 (misaligned) and bit 2 (protection) produce causes 2, 3 and 4. When several bits are set, the lowest-numbered set bit decides the cause.
- R2: `id_flt_i` (illegal opcode) produces cause 5 and `ex_flt_i` (arithmetic overflow) produces cause 6.
- R3: `mem_flt_i` bit 0 (page fault), bit 1 (misaligned), bit 2 (protection) and bit 3 (memory error) produce causes 7, 8, 9 and 10. When several bits are set, the lowest-numbered set bit decides the cause.
- R4: A fault reported in stage k at cycle t raises `redirect_o` in cycle t+4-k. In the cycle after that, `epc_o` holds the PC the stage reported and `cause_o` holds the cause.
- R5: In a redirect cycle, `redirect_pc_o` equals the handler address, `bubble_o` is all ones and `hold_o` is zero.
- R6: If several stages fault, only the oldest one traps. The oldest is the highest stage number, counting a tag already in flight at its current stage. The younger faults cause no redirect.
- R7: While a tag is in stage k (0..3) and nothing older faults, `hold_o` has ones exactly in bits below k and `bubble_o` has only bit k set.
- R8: `mem_wr_kill_o` is high while the instruction in memory is faulting and while a tag is in writeback. `rf_wr_kill_o` is high only while a tag is in writeback.
- R9: An interrupt accepted in cycle t, with no fault pending, drives hold bit 0 and bubble bit 1 in cycles t to t+2. It then redirects in cycle t+3 with cause 1 and saves the fetch PC seen in cycle t.
- R10: While an interrupt drain is under way, fetch faults are ignored. A fault in decode, execute or memory cancels the drain and traps normally.
- R11: During reset, all control outputs are low and the saved PC and cause read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_flt_i | input | 3 | Fetch fault strobes (page, misaligned, protection) |
| id_flt_i | input | 1 | Decode illegal-opcode strobe |
| ex_flt_i | input | 1 | Execute overflow strobe |
| mem_flt_i | input | 4 | Memory fault strobes (page, misaligned, protection, memory error) |
| if_pc_i | input | PC_W | PC in fetch |
| id_pc_i | input | PC_W | PC in decode |
| ex_pc_i | input | PC_W | PC in execute |
| mem_pc_i | input | PC_W | PC in memory |
| irq_i | input | 1 | External interrupt request |
| hold_o | output | 4 | Per-stage hold, bit 0 fetch to bit 3 memory |
| bubble_o | output | 5 | Per-stage bubble insert, bit 0 fetch to bit 4 writeback |
| mem_wr_kill_o | output | 1 | Suppress the memory write of the instruction in memory |
| rf_wr_kill_o | output | 1 | Suppress the register write of the instruction in writeback |
| redirect_o | output | 1 | Fetch takes the handler address next |
| redirect_pc_o | output | PC_W | Handler address while redirecting, zero otherwise |
| epc_o | output | PC_W | Saved restart PC |
| cause_o | output | 4 | Saved cause code |

## Verification
Some rules hold on every cycle, and the checker tests those. At most one tag is live at a time. A tag in writeback always produces a flush and both write kills. A tag in memory always advances to writeback. The hold vector is always a prefix of ones. Every redirect leaves a non-zero cause, and every redirect without a tag in writeback leaves the interrupt cause.

Other behaviour needs whole scenarios, and the bench's sequences cover it. These include the cause chosen for each strobe combination and the latency from each stage to the redirect. They also include the arbitration between two simultaneous faults, and the case where an older fault overtakes a tag already in flight. Finally, they cover the interrupt drain: its timing, its immunity to fetch faults, and its cancellation by an older exception.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int NSTG    = 5;
    localparam int NCHK    = NSTG - 1;
    localparam int IF_FW   = 3;
    localparam int MEM_FW  = 4;
    localparam int FW_MAX  = MEM_FW;
    localparam int CAUSE_W = 4;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t C_NONE     = 4'd0;
    localparam cause_t C_IRQ      = 4'd1;
    localparam cause_t C_IF_BASE  = 4'd2;
    localparam cause_t C_ID_BASE  = 4'd5;
    localparam cause_t C_EX_BASE  = 4'd6;
    localparam cause_t C_MEM_BASE = 4'd7;

    typedef enum logic {M_RUN, M_DRAIN} mode_t;

    function automatic cause_t stage_base(input int s);
        case (s)
            0:       return C_IF_BASE;
            1:       return C_ID_BASE;
            2:       return C_EX_BASE;
            default: return C_MEM_BASE;
        endcase
    endfunction

endpackage

// File: rtl/trap_cause_enc.sv
module trap_cause_enc
    import trap_pkg::*;
#(
    parameter int     N    = 1,
    parameter cause_t BASE = C_NONE
) (
    input  logic [N-1:0] flt_i,
    output logic         hit_o,
    output cause_t       code_o
);

    // lowest-numbered strobe decides the code
    always_comb begin
        hit_o  = |flt_i;
        code_o = C_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (flt_i[i]) code_o = BASE + CAUSE_W'(i);
        end
    end

endmodule

// File: rtl/trap_age_sel.sv
module trap_age_sel #(
    parameter int N     = 4,
    localparam int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    req_i,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o
);

    // highest stage index is the oldest instruction
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) idx_o = IDXW'(i);
        end
    end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IF_FW-1:0]  if_flt_i,
    input  logic              id_flt_i,
    input  logic              ex_flt_i,
    input  logic [MEM_FW-1:0] mem_flt_i,
    input  logic [PC_W-1:0]   if_pc_i,
    input  logic [PC_W-1:0]   id_pc_i,
    input  logic [PC_W-1:0]   ex_pc_i,
    input  logic [PC_W-1:0]   mem_pc_i,
    input  logic              irq_i,
    output logic [NCHK-1:0]   hold_o,
    output logic [NSTG-1:0]   bubble_o,
    output logic              mem_wr_kill_o,
    output logic              rf_wr_kill_o,
    output logic              redirect_o,
    output logic [PC_W-1:0]   redirect_pc_o,
    output logic [PC_W-1:0]   epc_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam int IDXW       = $clog2(NCHK);
    localparam int SLOTW      = $clog2(NSTG);
    localparam int CNT_W      = $clog2(NSTG);
    localparam int DRAIN_LAST = NSTG - 3;
    localparam int S_MEM      = NSTG - 2;
    localparam int S_WB       = NSTG - 1;

    typedef struct packed {
        logic [NSTG-1:1]               tv;
        logic [NSTG-1:1][CAUSE_W-1:0]  tc;
        logic [NSTG-1:1][PC_W-1:0]     tpc;
        logic [PC_W-1:0]               epc;
        cause_t                        cause;
        mode_t                         mode;
        logic [CNT_W-1:0]              cnt;
        logic [PC_W-1:0]               ipc;
    } st_t;

    st_t q, n;

    logic [NCHK-1:0][FW_MAX-1:0]  stage_flt;
    logic [NCHK-1:0][PC_W-1:0]    stage_pc;
    logic [NCHK-1:0]              enc_hit;
    logic [NCHK-1:0][CAUSE_W-1:0] enc_code;

    logic [NCHK-1:0]              eff_v;
    logic [NCHK-1:0][CAUSE_W-1:0] eff_c;
    logic [NCHK-1:0][PC_W-1:0]    eff_pc;

    logic            old_any;
    logic [IDXW-1:0] old_idx;

    logic [NCHK-1:0] hold_c;
    logic [NSTG-1:0] bubble_c;
    logic            rdr_c;
    logic            mkill_c;
    logic            rkill_c;
    logic [SLOTW-1:0] tgt;

    logic [NSTG-1:1] tag_live;
    assign tag_live = q.tv;

    assign stage_flt[0] = FW_MAX'(if_flt_i);
    assign stage_flt[1] = FW_MAX'(id_flt_i);
    assign stage_flt[2] = FW_MAX'(ex_flt_i);
    assign stage_flt[3] = mem_flt_i;

    assign stage_pc[0] = if_pc_i;
    assign stage_pc[1] = id_pc_i;
    assign stage_pc[2] = ex_pc_i;
    assign stage_pc[3] = mem_pc_i;

    for (genvar s = 0; s < NCHK; s++) begin : g_enc
        trap_cause_enc #(
            .N    (FW_MAX),
            .BASE (stage_base(s))
        ) u_enc (
            .flt_i  (stage_flt[s]),
            .hit_o  (enc_hit[s]),
            .code_o (enc_code[s])
        );
    end

    // a tag already riding with an instruction beats a new strobe for it
    always_comb begin
        eff_v     = '0;
        eff_c     = '0;
        eff_pc    = '0;
        eff_v[0]  = enc_hit[0] && (q.mode != M_DRAIN);
        eff_c[0]  = enc_code[0];
        eff_pc[0] = stage_pc[0];
        for (int s = 1; s < NCHK; s++) begin
            if (q.tv[s]) begin
                eff_v[s]  = 1'b1;
                eff_c[s]  = q.tc[s];
                eff_pc[s] = q.tpc[s];
            end else begin
                eff_v[s]  = enc_hit[s];
                eff_c[s]  = enc_code[s];
                eff_pc[s] = stage_pc[s];
            end
        end
    end

    trap_age_sel #(.N(NCHK)) u_age (
        .req_i (eff_v),
        .any_o (old_any),
        .idx_o (old_idx)
    );

    always_comb begin
        n        = q;
        n.tv     = '0;
        hold_c   = '0;
        bubble_c = '0;
        rdr_c    = 1'b0;
        mkill_c  = 1'b0;
        rkill_c  = 1'b0;
        tgt      = SLOTW'(old_idx) + SLOTW'(1);

        if (q.tv[S_WB]) begin
            rdr_c    = 1'b1;
            bubble_c = '1;
            rkill_c  = 1'b1;
            mkill_c  = 1'b1;
            n.epc    = q.tpc[S_WB];
            n.cause  = q.tc[S_WB];
            n.mode   = M_RUN;
            n.cnt    = '0;
        end else if (old_any) begin
            for (int s = 0; s < NCHK; s++) begin
                hold_c[s] = (s < int'(old_idx));
            end
            bubble_c[old_idx] = 1'b1;
            n.tv[tgt]         = 1'b1;
            n.tc[tgt]         = eff_c[old_idx];
            n.tpc[tgt]        = eff_pc[old_idx];
            mkill_c           = (int'(old_idx) == S_MEM);
            n.mode            = M_RUN;
            n.cnt             = '0;
        end else if (q.mode == M_DRAIN) begin
            if (q.cnt == CNT_W'(DRAIN_LAST)) begin
                rdr_c    = 1'b1;
                bubble_c = '1;
                n.epc    = q.ipc;
                n.cause  = C_IRQ;
                n.mode   = M_RUN;
                n.cnt    = '0;
            end else begin
                hold_c[0]   = 1'b1;
                bubble_c[1] = 1'b1;
                n.cnt       = q.cnt + CNT_W'(1);
            end
        end else if (irq_i) begin
            hold_c[0]   = 1'b1;
            bubble_c[1] = 1'b1;
            n.mode      = M_DRAIN;
            n.cnt       = '0;
            n.ipc       = if_pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign hold_o        = hold_c;
    assign bubble_o      = bubble_c;
    assign redirect_o    = rdr_c;
    assign redirect_pc_o = rdr_c ? HANDLER_PC : '0;
    assign mem_wr_kill_o = mkill_c;
    assign rf_wr_kill_o  = rkill_c;
    assign epc_o         = q.epc;
    assign cause_o       = q.cause;

endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
    import trap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NCHK-1:0]    hold_i,
    input logic [NSTG-1:0]    bubble_i,
    input logic               redirect_i,
    input logic               rf_kill_i,
    input logic               mem_kill_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic [NSTG-1:1]    tag_i
);

    p_single_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tag_i));

    p_wb_tag_traps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_i[NSTG-1] |-> redirect_i);

    p_mem_tag_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i[NSTG-2] && !tag_i[NSTG-1]) |=> tag_i[NSTG-1]);

    p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |-> ((&bubble_i) && (hold_i == '0)));

    p_cause_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (cause_i != C_NONE));

    p_hold_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(hold_i + NCHK'(1)));

    p_wb_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_i[NSTG-1] |-> (rf_kill_i && mem_kill_i));

    p_rf_kill_only_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_kill_i |-> tag_i[NSTG-1]);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_i && !tag_i[NSTG-1]) |=> (cause_i == C_IRQ));

endmodule

bind trap_ctrl trap_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold_o),
    .bubble_i   (bubble_o),
    .redirect_i (redirect_o),
    .rf_kill_i  (rf_wr_kill_o),
    .mem_kill_i (mem_wr_kill_o),
    .cause_i    (cause_o),
    .tag_i      (tag_live)
);

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;

    localparam int          CLK_PER = 10;
    localparam int          PCW     = 32;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     if_flt = '0;
    logic           id_flt = 1'b0;
    logic           ex_flt = 1'b0;
    logic [3:0]     mem_flt = '0;
    logic [PCW-1:0] if_pc = '0, id_pc = '0, ex_pc = '0, mem_pc = '0;
    logic           irq = 1'b0;

    logic [3:0]     hold_o;
    logic [4:0]     bubble_o;
    logic           mem_wr_kill_o, rf_wr_kill_o, redirect_o;
    logic [PCW-1:0] redirect_pc_o, epc_o;
    logic [3:0]     cause_o;

    trap_ctrl #(.PC_W(PCW), .HANDLER_PC(HANDLER)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .if_flt_i      (if_flt),
        .id_flt_i      (id_flt),
        .ex_flt_i      (ex_flt),
        .mem_flt_i     (mem_flt),
        .if_pc_i       (if_pc),
        .id_pc_i       (id_pc),
        .ex_pc_i       (ex_pc),
        .mem_pc_i      (mem_pc),
        .irq_i         (irq),
        .hold_o        (hold_o),
        .bubble_o      (bubble_o),
        .mem_wr_kill_o (mem_wr_kill_o),
        .rf_wr_kill_o  (rf_wr_kill_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .epc_o         (epc_o),
        .cause_o       (cause_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          when;
        logic [31:0] pc;
        logic [3:0]  cause;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_trap(int delay, logic [31:0] pc, logic [3:0] cause, string req);
        exp_t e;
        e.when  = cyc + delay;
        e.pc    = pc;
        e.cause = cause;
        e.req   = req;
        sbq.push_back(e);
    endtask

    task automatic next_cycle();
        @(negedge clk);
        if_flt  = '0;
        id_flt  = 1'b0;
        ex_flt  = 1'b0;
        mem_flt = '0;
        irq     = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) next_cycle();
    endtask

    task automatic fault_at(int stg, logic [3:0] v, logic [31:0] pc);
        case (stg)
            0:       begin if_flt  = v[2:0]; if_pc  = pc; end
            1:       begin id_flt  = v[0];   id_pc  = pc; end
            2:       begin ex_flt  = v[0];   ex_pc  = pc; end
            default: begin mem_flt = v;      mem_pc = pc; end
        endcase
    endtask

    task automatic check_ctl(string req, logic [3:0] h, logic [4:0] b);
        check_eq(req, "hold", hold_o, h);
        check_eq(req, "bubble", bubble_o, b);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // scoreboard monitor: pops one expected trap per redirect
    initial begin
        bit   pend;
        exp_t cur;
        pend = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (pend) begin
                check_eq(cur.req, "saved pc", epc_o, cur.pc);
                check_eq(cur.req, "cause", cause_o, cur.cause);
                pend = 1'b0;
            end
            if (rst_n && redirect_o) begin
                if (sbq.size() == 0) begin
                    check_eq("R6", "unexpected redirect", 1, 0);
                end else begin
                    cur = sbq.pop_front();
                    check_eq(cur.req, "redirect cycle", cyc, cur.when);
                    check_eq("R5", "handler pc", redirect_pc_o, HANDLER);
                    pend = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        check_eq("R11", "hold", hold_o, 0);
        check_eq("R11", "bubble", bubble_o, 0);
        check_eq("R11", "redirect", redirect_o, 0);
        check_eq("R11", "kills", {mem_wr_kill_o, rf_wr_kill_o}, 0);
        check_eq("R11", "epc", epc_o, 0);
        check_eq("R11", "cause", cause_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 R4 R7 R8: fetch fault with two strobes, walk the tag down
        next_cycle();
        fault_at(0, 4'b0110, 32'h100);
        expect_trap(4, 32'h100, 4'd3, "R1");
        #1; check_ctl("R7", 4'b0000, 5'b00001);
        next_cycle(); #1; check_ctl("R7", 4'b0001, 5'b00010);
        next_cycle(); #1; check_ctl("R7", 4'b0011, 5'b00100);
        next_cycle(); #1; check_ctl("R7", 4'b0111, 5'b01000);
        check_eq("R8", "mem kill in mem", mem_wr_kill_o, 1);
        check_eq("R8", "rf kill before wb", rf_wr_kill_o, 0);
        next_cycle(); #1;
        check_eq("R4", "redirect at t+4", redirect_o, 1);
        check_ctl("R5", 4'b0000, 5'b11111);
        check_eq("R8", "rf kill in wb", rf_wr_kill_o, 1);
        idle(4);

        // R1: remaining fetch codes
        next_cycle(); fault_at(0, 4'b0001, 32'h104); expect_trap(4, 32'h104, 4'd2, "R1");
        idle(6);
        next_cycle(); fault_at(0, 4'b0100, 32'h108); expect_trap(4, 32'h108, 4'd4, "R1");
        idle(6);

        // R2: decode and execute
        next_cycle(); fault_at(1, 4'b0001, 32'h200); expect_trap(3, 32'h200, 4'd5, "R2");
        #1; check_ctl("R7", 4'b0001, 5'b00010);
        idle(6);
        next_cycle(); fault_at(2, 4'b0001, 32'h240); expect_trap(2, 32'h240, 4'd6, "R2");
        idle(6);

        // R3 R8: memory codes and kills
        next_cycle(); fault_at(3, 4'b0001, 32'h300); expect_trap(1, 32'h300, 4'd7, "R3");
        #1;
        check_eq("R8", "mem kill", mem_wr_kill_o, 1);
        check_eq("R8", "rf kill early", rf_wr_kill_o, 0);
        next_cycle(); #1;
        check_eq("R8", "rf kill wb", rf_wr_kill_o, 1);
        check_eq("R8", "mem kill wb", mem_wr_kill_o, 1);
        idle(6);
        next_cycle(); fault_at(3, 4'b0110, 32'h304); expect_trap(1, 32'h304, 4'd8, "R3");
        idle(6);
        next_cycle(); fault_at(3, 4'b0100, 32'h308); expect_trap(1, 32'h308, 4'd9, "R3");
        idle(6);
        next_cycle(); fault_at(3, 4'b1000, 32'h30c); expect_trap(1, 32'h30c, 4'd10, "R3");
        idle(6);

        // R6: simultaneous fetch and execute faults, execute wins
        next_cycle();
        fault_at(0, 4'b0001, 32'h400);
        fault_at(2, 4'b0001, 32'h3f8);
        expect_trap(2, 32'h3f8, 4'd6, "R6");
        #1; check_ctl("R6", 4'b0011, 5'b00100);
        idle(6);

        // R6: older memory fault overtakes a decode tag in flight
        next_cycle(); fault_at(1, 4'b0001, 32'h420);
        next_cycle(); fault_at(3, 4'b0010, 32'h410);
        expect_trap(1, 32'h410, 4'd8, "R6");
        idle(6);

        // R9: interrupt drain
        next_cycle(); irq = 1'b1; if_pc = 32'h500;
        expect_trap(3, 32'h500, 4'd1, "R9");
        #1; check_ctl("R9", 4'b0001, 5'b00010);
        next_cycle(); if_pc = 32'h5f0; #1; check_ctl("R9", 4'b0001, 5'b00010);
        next_cycle(); #1; check_ctl("R9", 4'b0001, 5'b00010);
        next_cycle(); #1; check_eq("R9", "redirect at t+3", redirect_o, 1);
        idle(6);

        // R10: fetch fault during drain is ignored
        next_cycle(); irq = 1'b1; if_pc = 32'h600;
        expect_trap(3, 32'h600, 4'd1, "R10");
        next_cycle(); fault_at(0, 4'b0001, 32'h600);
        #1; check_ctl("R10", 4'b0001, 5'b00010);
        idle(7);

        // R10: execute fault cancels the drain
        next_cycle(); irq = 1'b1; if_pc = 32'h700;
        next_cycle(); fault_at(2, 4'b0001, 32'h6f8);
        expect_trap(2, 32'h6f8, 4'd6, "R10");
        #1; check_ctl("R10", 4'b0011, 5'b00100);
        idle(8);

        check_eq("R4", "traps left pending", sbq.size(), 0);
        summary();
        $finish;
    end

endmodule